// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block sits beside a real-time-clock counter. Once per second it receives an update strobe. On that strobe it compares the current seconds, minutes and hours bytes against three alarm bytes. It sets two sticky flags: an update-done flag on every strobe, and an alarm flag when the time matches. An interrupt request is raised when a flag goes from clear to set and that flag's enable is on.

Two encodings are handled:
- The data encoding of each byte, which is packed BCD or plain binary.
- The hour format, which is 24-hour, or 12-hour with an afternoon marker in bit 7.

Before any comparison, every field is converted to a binary, 24-hour value. An alarm byte with its two top bits both set is a wildcard and matches any value of that field. While the time-set hold is active, the clock is frozen. Updates still flag, but no new alarm match can occur, and the update interrupt is masked.

Software clears the flags and the interrupt with a one-cycle clear pulse, as a read-to-clear register would. The calendar arithmetic that advances the time is outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: While rst is high, upd_flag, alm_flag and irq are 0 after the next clock edge.
- R2: Every upd_stb pulse sets upd_flag, also while set_hold is 1.
- R3: On upd_stb with set_hold 0, alm_flag is set when every non-wildcard alarm field equals its current field. Otherwise alm_flag keeps its value.
- R4: bin_mode=1 compares bytes as binary. bin_mode=0 decodes packed BCD as high nibble × 10 + low nibble before comparing. For example, 0x10 and 0x0A are equal in BCD mode and unequal in binary mode.
- R5: An alarm byte whose bits 7:6 are 2'b11 matches any value of its field.
- R6: With h24_mode=0, the hour value in bits 6:0 is taken modulo 12, and bit 7 (PM) adds 12. So 12 AM (0x12 in BCD) equals hour 0 (0x00), and differs from 12 PM (0x92). With h24_mode=1, the whole byte is the hour.
- R7: With all three alarm bytes wildcards, every update strobe sets alm_flag.
- R8: irq is set only on an upd_stb that newly sets a flag whose enable is 1 (uie for upd_flag, aie for alm_flag). A flag that is already set raises no interrupt. irq stays set until cleared.
- R9: While set_hold is 1, an update strobe sets no alarm flag, and upd_flag raises no interrupt even when uie is 1.
- R10: A flag_clr pulse clears upd_flag, alm_flag and irq after the next edge. When upd_stb arrives in the same cycle, the flags it sets are applied after the clear, and they count as new.
- R11: In a cycle with neither upd_stb nor flag_clr, the flags and irq keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle pulse that marks the end of a one-second update |
| flag_clr | input | 1 | One-cycle pulse that clears the flags and irq |
| set_hold | input | 1 | Time-set hold: clock frozen, no alarm, update interrupt masked |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| uie | input | 1 | Update-done interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| upd_flag | output | 1 | Sticky update-done flag |
| alm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Sticky interrupt request |

## Verification
Every result is registered once. A strobe or clear sampled at a rising edge is therefore visible on upd_flag, alm_flag and irq right after that same edge, which is a latency of one cycle. The decode and compare path is purely combinational ahead of that register.

The bench drives inputs on the falling edge and holds a pulse for exactly one cycle. It reads the outputs on the next falling edge, half a cycle after the registering edge. It also holds idle cycles before sampling to show that the flags keep their values between strobes.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;
    localparam int HALF_DAY   = 12;

    typedef enum logic [1:0] {
        FLD_SEC = 2'd0,
        FLD_MIN = 2'd1,
        FLD_HR  = 2'd2
    } fld_e;

    typedef struct packed {
        logic bin;
        logic h24;
        logic hold;
        logic uie;
        logic aie;
    } mode_t;

    typedef struct packed {
        logic uf;
        logic af;
        logic irq;
    } flags_t;

    // True when the alarm byte is a don't-care code (bits 7:6 both set).
    function automatic logic is_wild(input logic [BYTE_W-1:0] v);
        return v[BYTE_W-1] & v[BYTE_W-2];
    endfunction

    // Convert a field byte to binary: pass-through or packed BCD decode.
    function automatic logic [BYTE_W-1:0] fld_dec(input logic [BYTE_W-1:0] v,
                                                 input logic bin);
        logic [BYTE_W-1:0] tens;
        logic [BYTE_W-1:0] units;
        tens  = {4'b0000, v[7:4]};
        units = {4'b0000, v[3:0]};
        if (bin)
            return v;
        return (tens * 8'd10) + units;
    endfunction

    // Hour in 24-hour binary form, folding the 12-hour PM marker.
    function automatic logic [BYTE_W-1:0] hr_norm(input logic [BYTE_W-1:0] v,
                                                 input logic bin,
                                                 input logic h24);
        logic [BYTE_W-1:0] t;
        if (h24)
            return fld_dec(v, bin);
        t = fld_dec({1'b0, v[BYTE_W-2:0]}, bin);
        t = t % BYTE_W'(HALF_DAY);
        if (v[BYTE_W-1])
            t = t + BYTE_W'(HALF_DAY);
        return t;
    endfunction

endpackage

// File: rtl/rtc_alm_field.sv
module rtc_alm_field
    import rtc_alm_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] alm,
    input  logic              bin_mode,
    input  logic              h24_mode,
    output logic              hit
);
    logic [BYTE_W-1:0] cur_n;
    logic [BYTE_W-1:0] alm_n;

    generate
        if (IS_HOUR) begin : g_hour
            always_comb begin
                cur_n = hr_norm(cur, bin_mode, h24_mode);
                alm_n = hr_norm(alm, bin_mode, h24_mode);
            end
        end else begin : g_plain
            always_comb begin
                cur_n = fld_dec(cur, bin_mode);
                alm_n = fld_dec(alm, bin_mode);
            end
        end
    endgenerate

    assign hit = is_wild(alm) | (cur_n == alm_n);
endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
    import rtc_alm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_stb,
    input  logic   flag_clr,
    input  mode_t  mode,
    input  logic   match,
    output flags_t flags
);
    flags_t q;
    flags_t base;
    flags_t nxt;
    logic   set_uf;
    logic   set_af;
    logic   new_uf;
    logic   new_af;
    logic   uie_eff;

    always_comb begin
        base    = flag_clr ? '0 : q;
        set_uf  = upd_stb;
        set_af  = upd_stb & match & ~mode.hold;
        uie_eff = mode.uie & ~mode.hold;
        new_uf  = set_uf & ~base.uf;
        new_af  = set_af & ~base.af;
        nxt.uf  = base.uf | set_uf;
        nxt.af  = base.af | set_af;
        nxt.irq = base.irq | (new_uf & uie_eff) | (new_af & mode.aie);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    assign flags = q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_stb,
    input  logic              flag_clr,
    input  logic              set_hold,
    input  logic              bin_mode,
    input  logic              h24_mode,
    input  logic              uie,
    input  logic              aie,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hr,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hr,
    output logic              upd_flag,
    output logic              alm_flag,
    output logic              irq
);
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] cur_v;
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_v;
    logic [NUM_FIELDS-1:0]             hit;
    mode_t                             mode;
    flags_t                            flags;

    always_comb begin
        cur_v[FLD_SEC] = cur_sec;
        cur_v[FLD_MIN] = cur_min;
        cur_v[FLD_HR]  = cur_hr;
        alm_v[FLD_SEC] = alm_sec;
        alm_v[FLD_MIN] = alm_min;
        alm_v[FLD_HR]  = alm_hr;
        mode.bin  = bin_mode;
        mode.h24  = h24_mode;
        mode.hold = set_hold;
        mode.uie  = uie;
        mode.aie  = aie;
    end

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
            rtc_alm_field #(.IS_HOUR(i == int'(FLD_HR))) u_fld (
                .cur      (cur_v[i]),
                .alm      (alm_v[i]),
                .bin_mode (bin_mode),
                .h24_mode (h24_mode),
                .hit      (hit[i])
            );
        end
    endgenerate

    rtc_alm_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .upd_stb  (upd_stb),
        .flag_clr (flag_clr),
        .mode     (mode),
        .match    (&hit),
        .flags    (flags)
    );

    assign upd_flag = flags.uf;
    assign alm_flag = flags.af;
    assign irq      = flags.irq;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
    input logic clk,
    input logic rst,
    input logic upd_stb,
    input logic flag_clr,
    input logic set_hold,
    input logic upd_flag,
    input logic alm_flag,
    input logic irq
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!upd_flag && !alm_flag && !irq));

    p_uf_on_stb_r2: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> upd_flag);

    p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (upd_flag || alm_flag));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(upd_stb));

    p_hold_no_af_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && set_hold && !alm_flag && !flag_clr) |=> !alm_flag);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !upd_stb) |=> (!upd_flag && !alm_flag && !irq));

    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && !flag_clr) |=> ($stable(upd_flag) && $stable(alm_flag) && $stable(irq)));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd_stb  (upd_stb),
    .flag_clr (flag_clr),
    .set_hold (set_hold),
    .upd_flag (upd_flag),
    .alm_flag (alm_flag),
    .irq      (irq)
);

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_stb = 1'b0, flag_clr = 1'b0, set_hold = 1'b0;
    logic bin_mode = 1'b1, h24_mode = 1'b1, uie = 1'b0, aie = 1'b0;
    logic [7:0] cur_sec = 8'd0, cur_min = 8'd0, cur_hr = 8'd0;
    logic [7:0] alm_sec = 8'd0, alm_min = 8'd0, alm_hr = 8'd0;
    logic upd_flag, alm_flag, irq;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_alarm_match u0 (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Pulse strobe and/or clear for one cycle; outputs are sampled on the next falling edge.
    task automatic pulse(input logic s, input logic c);
        @(negedge clk);
        upd_stb = s; flag_clr = c;
        @(negedge clk);
        upd_stb = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        cur_hr = h; cur_min = m; cur_sec = s;
    endtask

    task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        alm_hr = h; alm_min = m; alm_sec = s;
    endtask

    task automatic t_reset;
        chk("R1 uf", upd_flag, 1'b0);
        chk("R1 af", alm_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_update_and_hold;
        bin_mode = 1; h24_mode = 1; uie = 0; aie = 0;
        set_time(8'd10, 8'd20, 8'd30);
        set_alarm(8'd10, 8'd20, 8'd31);
        pulse(1, 0);
        chk("R2 uf set", upd_flag, 1'b1);
        chk("R3 no match", alm_flag, 1'b0);
        chk("R8 no enable no irq", irq, 1'b0);
        repeat (3) @(negedge clk);
        chk("R11 uf held", upd_flag, 1'b1);
        pulse(0, 1);
        chk("R10 uf cleared", upd_flag, 1'b0);
    endtask

    task automatic t_binary_match;
        aie = 1;
        set_alarm(8'd10, 8'd20, 8'd30);
        pulse(1, 0);
        chk("R3 match af", alm_flag, 1'b1);
        chk("R8 af irq", irq, 1'b1);
        repeat (2) @(negedge clk);
        chk("R11 irq held", irq, 1'b1);
        pulse(0, 1);
        chk("R10 irq cleared", irq, 1'b0);
        chk("R10 af cleared", alm_flag, 1'b0);
        aie = 0;
        pulse(1, 0);
        chk("R3 match af without aie", alm_flag, 1'b1);
        chk("R8 af no aie no irq", irq, 1'b0);
        pulse(0, 1);
    endtask

    task automatic t_bcd;
        bin_mode = 0;
        set_time(8'h10, 8'h20, 8'h10);
        set_alarm(8'h10, 8'h20, 8'h0A);
        pulse(1, 0);
        chk("R4 bcd 0x10==0x0A", alm_flag, 1'b1);
        pulse(0, 1);
        bin_mode = 1;
        pulse(1, 0);
        chk("R4 binary 0x10!=0x0A", alm_flag, 1'b0);
        pulse(0, 1);
        bin_mode = 0;
        set_time(8'h23, 8'h59, 8'h58);
        set_alarm(8'h23, 8'h59, 8'h59);
        pulse(1, 0);
        chk("R4 bcd 58!=59", alm_flag, 1'b0);
        pulse(0, 1);
    endtask

    task automatic t_wild;
        bin_mode = 1;
        set_time(8'd5, 8'd6, 8'd7);
        set_alarm(8'd5, 8'd6, 8'hC5);
        pulse(1, 0);
        chk("R5 sec wildcard", alm_flag, 1'b1);
        pulse(0, 1);
        set_alarm(8'd5, 8'hFF, 8'd9);
        pulse(1, 0);
        chk("R5 min wild sec mismatch", alm_flag, 1'b0);
        pulse(0, 1);
        set_alarm(8'hC0, 8'hC0, 8'hC0);
        for (int i = 0; i < 3; i++) begin
            set_time(8'(i * 7), 8'(i * 13), 8'(i * 19 + 1));
            pulse(1, 0);
            chk("R7 all wild", alm_flag, 1'b1);
            pulse(0, 1);
        end
    endtask

    task automatic t_12h;
        bin_mode = 0; h24_mode = 0;
        set_time(8'h12, 8'h00, 8'h00);
        set_alarm(8'h00, 8'h00, 8'h00);
        pulse(1, 0);
        chk("R6 12AM==0", alm_flag, 1'b1);
        pulse(0, 1);
        set_alarm(8'h92, 8'h00, 8'h00);
        pulse(1, 0);
        chk("R6 12AM!=12PM", alm_flag, 1'b0);
        pulse(0, 1);
        set_time(8'h81, 8'h00, 8'h00);
        set_alarm(8'h81, 8'h00, 8'h00);
        pulse(1, 0);
        chk("R6 1PM==1PM", alm_flag, 1'b1);
        pulse(0, 1);
        set_alarm(8'h01, 8'h00, 8'h00);
        pulse(1, 0);
        chk("R6 1PM!=1AM", alm_flag, 1'b0);
        pulse(0, 1);
        h24_mode = 1; bin_mode = 1;
    endtask

    task automatic t_new_only;
        uie = 0; aie = 0;
        pulse(1, 0);
        chk("R8 uf set no irq", irq, 1'b0);
        uie = 1;
        pulse(1, 0);
        chk("R8 old uf no irq", irq, 1'b0);
        pulse(0, 1);
        pulse(1, 0);
        chk("R8 new uf irq", irq, 1'b1);
        pulse(0, 1);
    endtask

    task automatic t_set_hold;
        set_hold = 1; uie = 1; aie = 1;
        set_time(8'd1, 8'd2, 8'd3);
        set_alarm(8'd1, 8'd2, 8'd3);
        pulse(1, 0);
        chk("R9 uf still set", upd_flag, 1'b1);
        chk("R9 no af", alm_flag, 1'b0);
        chk("R9 no irq", irq, 1'b0);
        pulse(0, 1);
        set_hold = 0;
    endtask

    task automatic t_clr_and_stb;
        uie = 0; aie = 0;
        set_alarm(8'd1, 8'd2, 8'd4);
        pulse(1, 0);
        uie = 1;
        pulse(1, 1);
        chk("R10 stb wins uf", upd_flag, 1'b1);
        chk("R10 uf new after clear irq", irq, 1'b1);
        pulse(0, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_update_and_hold();
        t_binary_match();
        t_bcd();
        t_wild();
        t_12h();
        t_new_only();
        t_set_hold();
        t_clr_and_stb();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule